// File: doc/BRIEF.md
# GPIO Expander Interrupt-on-Change Core

This block is an eight-pin general-purpose I/O port that sits behind a simple synchronous register interface. It has an 8-bit address and 8-bit write and read data. Software sets, for each pin, whether it drives or listens, what level it drives, whether a pull-up is on, and whether its input is inverted. The block drives the pad output-enable, output and pull-up lines, and it samples the pad inputs through a two-flop synchronizer.

Each enabled pin can raise the single interrupt line in one of two ways. In edge-like mode it fires when its sampled value moves away from the previous sample. In compare mode it fires for as long as it differs from a software-chosen reference bit. When the interrupt is raised, a flag register marks the single pin that caused it and a capture register freezes the whole port. Both then hold until a read clears the pending state. A configuration bit chooses whether that clearing read is the port read or the capture read. The interrupt pin can be driven push-pull at either polarity, or driven open-drain.

Top module: `gpio_ioc_core`

## Requirements
- R1: After reset the direction register (0x00) reads 0xFF and every other register reads 0x00. No pad is driven. The interrupt line is inactive: push-pull, driven high.
- R2: The registers at 0x00 (direction), 0x01 (input invert), 0x02 (interrupt enable), 0x03 (reference value), 0x04 (mode, 1 = compare), 0x05 (configuration), 0x06 (pull-up) and 0x0A (output latch) read back the last value written to them.
- R3: The output enable of pad i equals the inverse of direction bit i. The pad output carries latch bit i for output pins and 0 for input pins. The pull-up of pad i equals pull-up bit i.
- R4: Reading 0x09 returns the pad inputs as they were two clock edges earlier, XORed with the input-invert register.
- R5: An enabled pin in mode 0 raises the interrupt on the third rising edge after its pad changes, when its port value differs from the previous sample.
- R6: An enabled pin in mode 1 raises the interrupt while its port value differs from its reference bit. The interrupt raises again after a clear if the mismatch remains.
- R7: A pin whose interrupt-enable bit is 0 never raises the interrupt and never appears in the flag register.
- R8: When the interrupt is raised, the flag register (0x07) holds only the lowest-numbered triggering pin. The capture register (0x08) holds the port value of that cycle.
- R9: While the interrupt is pending, the flag and capture registers do not change, whatever the pins do.
- R10: With configuration bit 0 at 0, a read of 0x09 clears the pending interrupt and the flag, and a read of 0x08 does not. With configuration bit 0 at 1, the roles are swapped.
- R11: With configuration bit 2 at 0, the interrupt line is driven, and it is at the level of configuration bit 1 when pending and at the inverse level otherwise. With bit 2 at 1, the line outputs 0 and its enable is on only while pending, whatever bit 1 holds.
- R12: Writes to 0x07, 0x08 and 0x09 change nothing. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers clear-on-read) |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output levels |
| pad_pu | output | 8 | Pad pull-up enables |
| irq_out | output | 1 | Interrupt line level |
| irq_oe | output | 1 | Interrupt line drive enable |

## Verification
The assertions assume that a read and a write never occur in the same cycle and that the pad inputs are free to change at any time. The stimulus issues one register access per cycle and changes the pads only on the falling clock edge. The hold and priority properties assume that the enable mask seen at the raising edge is the one that was written before that edge. The bench makes every configuration write at least one cycle before the pad change it is meant to act on.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADR_DIR  = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_INV  = 8'h01;
  localparam logic [ADDR_W-1:0] ADR_IEN  = 8'h02;
  localparam logic [ADDR_W-1:0] ADR_REF  = 8'h03;
  localparam logic [ADDR_W-1:0] ADR_MODE = 8'h04;
  localparam logic [ADDR_W-1:0] ADR_CFG  = 8'h05;
  localparam logic [ADDR_W-1:0] ADR_PU   = 8'h06;
  localparam logic [ADDR_W-1:0] ADR_FLAG = 8'h07;
  localparam logic [ADDR_W-1:0] ADR_CAP  = 8'h08;
  localparam logic [ADDR_W-1:0] ADR_PORT = 8'h09;
  localparam logic [ADDR_W-1:0] ADR_LAT  = 8'h0A;

  // configuration bit positions with behaviour attached
  localparam int CFG_CLR_SEL  = 0;
  localparam int CFG_ACT_HIGH = 1;
  localparam int CFG_OPEN_DRN = 2;
endpackage

// File: rtl/gpio_ioc_regs.sv
module gpio_ioc_regs
  import gpio_ioc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      inv_q,
  output logic [W-1:0]      ien_q,
  output logic [W-1:0]      ref_q,
  output logic [W-1:0]      mode_q,
  output logic [W-1:0]      cfg_q,
  output logic [W-1:0]      pu_q,
  output logic [W-1:0]      lat_q
);
  logic en_dir, en_inv, en_ien, en_ref, en_mode, en_cfg, en_pu, en_lat;

  always_comb begin
    en_dir  = wr && (addr == ADR_DIR);
    en_inv  = wr && (addr == ADR_INV);
    en_ien  = wr && (addr == ADR_IEN);
    en_ref  = wr && (addr == ADR_REF);
    en_mode = wr && (addr == ADR_MODE);
    en_cfg  = wr && (addr == ADR_CFG);
    en_pu   = wr && (addr == ADR_PU);
    en_lat  = wr && (addr == ADR_LAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      inv_q  <= '0;
      ien_q  <= '0;
      ref_q  <= '0;
      mode_q <= '0;
      cfg_q  <= '0;
      pu_q   <= '0;
      lat_q  <= '0;
    end else begin
      if (en_dir)  dir_q  <= wdata;
      if (en_inv)  inv_q  <= wdata;
      if (en_ien)  ien_q  <= wdata;
      if (en_ref)  ref_q  <= wdata;
      if (en_mode) mode_q <= wdata;
      if (en_cfg)  cfg_q  <= wdata;
      if (en_pu)   pu_q   <= wdata;
      if (en_lat)  lat_q  <= wdata;
    end
  end

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADR_DIR) |=> (dir_q == $past(wdata)));

  // R2
  lat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr) |=> $stable(lat_q) && $stable(dir_q) && $stable(ien_q));
endmodule

// File: rtl/gpio_ioc_insync.sv
module gpio_ioc_insync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  input  logic [W-1:0] inv,
  output logic [W-1:0] port_val
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = pad_in;
    end else begin : g_next
      always_comb stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  always_comb port_val = stage_q[STAGES-1] ^ inv;
endmodule

// File: rtl/gpio_ioc_detect.sv
module gpio_ioc_detect
  import gpio_ioc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      port_val,
  input  logic [W-1:0]      ien,
  input  logic [W-1:0]      ref_val,
  input  logic [W-1:0]      mode,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              clr_sel,
  output logic              pend_q,
  output logic [W-1:0]      flag_q,
  output logic [W-1:0]      cap_q
);
  logic [W-1:0] prev_q;
  logic [W-1:0] cand, first;
  logic [W-1:0] flag_d, cap_d;
  logic         pend_d, clr, fire;
  logic [ADDR_W-1:0] clr_addr;

  always_comb begin
    cand     = ien & ((mode & (port_val ^ ref_val)) | (~mode & (port_val ^ prev_q)));
    first    = cand & (~cand + {{(W-1){1'b0}}, 1'b1});
    clr_addr = clr_sel ? ADR_CAP : ADR_PORT;
    clr      = pend_q && rd && (addr == clr_addr);
    fire     = !pend_q && (|cand);
    pend_d   = pend_q;
    flag_d   = flag_q;
    cap_d    = cap_q;
    if (clr) begin
      pend_d = 1'b0;
      flag_d = '0;
    end else if (fire) begin
      pend_d = 1'b1;
      flag_d = first;
      cap_d  = port_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= 1'b0;
      flag_q <= '0;
      cap_q  <= '0;
    end else begin
      prev_q <= port_val;
      pend_q <= pend_d;
      flag_q <= flag_d;
      cap_q  <= cap_d;
    end
  end

  // R8
  flag_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> ($countones(flag_q) == 1));

  // R9
  hold_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !(rd && addr == clr_addr)) |=> ($stable(flag_q) && $stable(cap_q) && pend_q));

  // R7
  enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> ((flag_q & ~$past(ien)) == '0));

  // R10
  clear_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && rd && addr == (clr_sel ? ADR_CAP : ADR_PORT)) |=> (flag_q == '0));
endmodule

// File: rtl/gpio_ioc_core.sv
module gpio_ioc_core
  import gpio_ioc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_pu,
  output logic              irq_out,
  output logic              irq_oe
);
  logic [1:0]   rs_q;
  logic         rst_ns;
  logic [W-1:0] dir_q, inv_q, ien_q, ref_q, mode_q, cfg_q, pu_q, lat_q;
  logic [W-1:0] port_val, flag_q, cap_q;
  logic         pend_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  always_comb rst_ns = rs_q[1];

  gpio_ioc_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_ns), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .dir_q(dir_q), .inv_q(inv_q), .ien_q(ien_q), .ref_q(ref_q),
    .mode_q(mode_q), .cfg_q(cfg_q), .pu_q(pu_q), .lat_q(lat_q)
  );

  gpio_ioc_insync #(.W(W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_ns), .pad_in(pad_in), .inv(inv_q), .port_val(port_val)
  );

  gpio_ioc_detect #(.W(W)) u_det (
    .clk(clk), .rst_n(rst_ns), .port_val(port_val), .ien(ien_q), .ref_val(ref_q),
    .mode(mode_q), .rd(reg_rd), .addr(reg_addr), .clr_sel(cfg_q[CFG_CLR_SEL]),
    .pend_q(pend_q), .flag_q(flag_q), .cap_q(cap_q)
  );

  always_comb begin
    case (reg_addr)
      ADR_DIR:  reg_rdata = dir_q;
      ADR_INV:  reg_rdata = inv_q;
      ADR_IEN:  reg_rdata = ien_q;
      ADR_REF:  reg_rdata = ref_q;
      ADR_MODE: reg_rdata = mode_q;
      ADR_CFG:  reg_rdata = cfg_q;
      ADR_PU:   reg_rdata = pu_q;
      ADR_FLAG: reg_rdata = flag_q;
      ADR_CAP:  reg_rdata = cap_q;
      ADR_PORT: reg_rdata = port_val;
      ADR_LAT:  reg_rdata = lat_q;
      default:  reg_rdata = '0;
    endcase
  end

  always_comb begin
    pad_oe  = ~dir_q;
    pad_out = lat_q & ~dir_q;
    pad_pu  = pu_q;
    if (cfg_q[CFG_OPEN_DRN]) begin
      irq_out = 1'b0;
      irq_oe  = pend_q;
    end else begin
      irq_out = pend_q ? cfg_q[CFG_ACT_HIGH] : ~cfg_q[CFG_ACT_HIGH];
      irq_oe  = 1'b1;
    end
  end

  // R11
  open_drain_release_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (cfg_q[CFG_OPEN_DRN] && !pend_q) |-> (!irq_oe && !irq_out));

  // R11
  push_pull_level_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!cfg_q[CFG_OPEN_DRN] && u_det.pend_q) |-> (irq_oe && irq_out == cfg_q[CFG_ACT_HIGH]));

  // R3
  input_pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ((pad_out & ~pad_oe) == '0));
endmodule

// File: tb/gpio_ioc_core_test.sv
module gpio_ioc_core_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] pad_in, pad_oe, pad_out, pad_pu;
  logic       irq_out, irq_oe;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  gpio_ioc_core uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
    .irq_out(irq_out), .irq_oe(irq_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=00 exp=01");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, p, exp_flag, cap_old;
    logic [7:0] wa [8];
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0; pad_in = 8'h00;
    rst_n = 0;
    waitn(3);
    rst_n = 1;
    waitn(4);

    // R1 reset state
    rd(8'h00, v); chk(v == 8'hFF, "R1 dir", v, 8'hFF);
    for (int a = 1; a <= 10; a++) begin
      rd(a[7:0], v); chk(v == 8'h00, "R1 reg", v, 8'h00);
    end
    chk(pad_oe == 8'h00, "R1 pad_oe", pad_oe, 8'h00);
    chk(irq_out == 1'b1 && irq_oe == 1'b1, "R1 irq", {6'd0, irq_oe, irq_out}, 8'h03);

    // R2 readback (mode and enables stay idle while pads are quiet)
    wa = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h0A};
    for (int i = 0; i < 8; i++) begin
      wr(wa[i], 8'hA5 ^ wa[i]);
      rd(wa[i], v); chk(v == (8'hA5 ^ wa[i]), "R2 readback", v, 8'hA5 ^ wa[i]);
    end
    wr(8'h02, 8'h00); wr(8'h05, 8'h00); wr(8'h01, 8'h00); wr(8'h03, 8'h00);
    wr(8'h04, 8'h00); wr(8'h06, 8'h00); wr(8'h0A, 8'h00); wr(8'h00, 8'hFF);
    waitn(4);

    // R12 read-only and unmapped
    wr(8'h07, 8'hFF); wr(8'h08, 8'hFF); wr(8'h09, 8'hFF);
    rd(8'h07, v); chk(v == 8'h00, "R12 flag ro", v, 8'h00);
    rd(8'h08, v); chk(v == 8'h00, "R12 cap ro", v, 8'h00);
    rd(8'h09, v); chk(v == 8'h00, "R12 port ro", v, 8'h00);
    rd(8'h0B, v); chk(v == 8'h00, "R12 unmapped", v, 8'h00);
    rd(8'hFF, v); chk(v == 8'h00, "R12 unmapped", v, 8'h00);

    // R3 pad drive sweep over every direction pattern
    for (int d = 0; d < 256; d++) begin
      wr(8'h0A, ~d[7:0] ^ 8'h3C);
      wr(8'h00, d[7:0]);
      wr(8'h06, d[7:0] ^ 8'h99);
      chk(pad_oe == ~d[7:0], "R3 oe", pad_oe, ~d[7:0]);
      chk(pad_out == ((~d[7:0] ^ 8'h3C) & ~d[7:0]), "R3 out", pad_out, (~d[7:0] ^ 8'h3C) & ~d[7:0]);
      chk(pad_pu == (d[7:0] ^ 8'h99), "R3 pu", pad_pu, d[7:0] ^ 8'h99);
    end
    wr(8'h00, 8'hFF); wr(8'h06, 8'h00); wr(8'h0A, 8'h00);

    // R4 input path sweep with three invert masks
    for (int k = 0; k < 3; k++) begin
      p = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'h5A;
      wr(8'h01, p);
      for (int x = 0; x < 256; x++) begin
        pad_in = x[7:0];
        waitn(2);
        rd(8'h09, v); chk(v == (x[7:0] ^ p), "R4 port", v, x[7:0] ^ p);
      end
    end
    wr(8'h01, 8'h00);
    pad_in = 8'h00;
    waitn(4);

    // R5 R8 change mode, every change mask
    wr(8'h04, 8'h00); wr(8'h05, 8'h00); wr(8'h02, 8'hFF);
    waitn(2);
    for (int m = 1; m < 256; m++) begin
      pad_in = pad_in ^ m[7:0];
      waitn(2);
      chk(irq_out == 1'b1, "R5 not before third edge", {7'd0, irq_out}, 8'h01);
      waitn(1);
      chk(irq_out == 1'b0, "R5 raised", {7'd0, irq_out}, 8'h00);
      exp_flag = m[7:0] & (~m[7:0] + 8'd1);
      rd(8'h07, v); chk(v == exp_flag, "R8 flag lowest", v, exp_flag);
      rd(8'h08, v); chk(v == pad_in, "R8 capture", v, pad_in);
      rd(8'h09, v);
      chk(irq_out == 1'b1, "R10 port read clears", {7'd0, irq_out}, 8'h01);
    end

    // R7 disabled pins
    wr(8'h02, 8'h0F);
    pad_in = pad_in ^ 8'hF0;
    waitn(4);
    chk(irq_out == 1'b1, "R7 disabled quiet", {7'd0, irq_out}, 8'h01);
    rd(8'h07, v); chk(v == 8'h00, "R7 no flag", v, 8'h00);
    pad_in = pad_in ^ 8'h34;
    waitn(4);
    rd(8'h07, v); chk(v == 8'h04, "R7 enabled pin only", v, 8'h04);
    cap_old = pad_in;

    // R9 hold while pending
    pad_in = pad_in ^ 8'h03;
    waitn(4);
    rd(8'h07, v); chk(v == 8'h04, "R9 flag held", v, 8'h04);
    rd(8'h08, v); chk(v == cap_old, "R9 capture held", v, cap_old);
    rd(8'h09, v);
    waitn(2);
    chk(irq_out == 1'b1, "R9 stays clear", {7'd0, irq_out}, 8'h01);

    // R6 compare mode
    wr(8'h02, 8'hFF); wr(8'h03, pad_in); wr(8'h04, 8'hFF);
    waitn(3);
    chk(irq_out == 1'b1, "R6 match quiet", {7'd0, irq_out}, 8'h01);
    wr(8'h03, pad_in ^ 8'h10);
    waitn(3);
    rd(8'h07, v); chk(v == 8'h10, "R6 mismatch flag", v, 8'h10);
    rd(8'h09, v);
    waitn(1);
    chk(irq_out == 1'b0, "R6 re-raise", {7'd0, irq_out}, 8'h00);
    wr(8'h03, pad_in);
    rd(8'h09, v);
    waitn(2);
    chk(irq_out == 1'b1, "R6 match clears", {7'd0, irq_out}, 8'h01);
    wr(8'h04, 8'h00);
    waitn(2);

    // R10 clear source selection
    pad_in = pad_in ^ 8'h08;
    waitn(4);
    rd(8'h08, v);
    chk(irq_out == 1'b0, "R10 cap read no clear", {7'd0, irq_out}, 8'h00);
    rd(8'h09, v);
    chk(irq_out == 1'b1, "R10 port clears", {7'd0, irq_out}, 8'h01);
    wr(8'h05, 8'h01);
    pad_in = pad_in ^ 8'h08;
    waitn(4);
    rd(8'h09, v);
    chk(irq_out == 1'b0, "R10 port read no clear", {7'd0, irq_out}, 8'h00);
    rd(8'h08, v);
    chk(irq_out == 1'b1, "R10 cap clears", {7'd0, irq_out}, 8'h01);

    // R11 output styles
    wr(8'h05, 8'h02);
    chk(irq_out == 1'b0 && irq_oe, "R11 act-high idle", {6'd0, irq_oe, irq_out}, 8'h02);
    pad_in = pad_in ^ 8'h01;
    waitn(4);
    chk(irq_out == 1'b1 && irq_oe, "R11 act-high pend", {6'd0, irq_oe, irq_out}, 8'h03);
    rd(8'h09, v);
    for (int c = 0; c < 2; c++) begin
      wr(8'h05, c ? 8'h06 : 8'h04);
      chk(!irq_out && !irq_oe, "R11 od idle", {6'd0, irq_oe, irq_out}, 8'h00);
      pad_in = pad_in ^ 8'h01;
      waitn(4);
      chk(!irq_out && irq_oe, "R11 od pend", {6'd0, irq_oe, irq_out}, 8'h02);
      rd(8'h09, v);
      chk(!irq_oe, "R11 od release", {6'd0, irq_oe, irq_out}, 8'h00);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule